// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address stream for a four-beat burst. A load strobe captures a full external address, and that address is the first address of the burst. The block then produces the next three addresses itself. Only the two least significant bits change. They are derived from a 2-bit beat counter and the starting low bits.

A static ordering input selects the sequence. With the input low the low bits count up by one and wrap modulo four. With the input high the low bits are the starting bits XOR the beat count. An active-low step input advances the sequence by one beat. While it is high the current address is held, which inserts wait states. A new load ends any burst in progress at once.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the address register and the beat counter clear, so `burst_addr` and `beat` read zero.
- R2: On a clock edge with `load` high, `burst_addr` equals the `ext_addr` value sampled at that edge, and `beat` becomes 0 from the following cycle.
- R3: With `interleave` low, each step adds one modulo 4 to `burst_addr[1:0]`. A start of 01 gives 01, 10, 11, 00.
- R4: With `interleave` high, `burst_addr[1:0]` equals the loaded low bits XOR `beat`. A start of 10 gives 10, 11, 00, 01, and a start of 11 gives 11, 10, 01, 00.
- R5: An edge with `load` low and `step_n` high leaves both `burst_addr` and `beat` unchanged.
- R6: Bits above bit 1 of `burst_addr` keep their loaded value on every edge without `load`.
- R7: A load in the middle of a burst discards that burst and starts the new address at beat 0.
- R8: A step taken at beat 3 wraps `beat` to 0, and `burst_addr` returns to the loaded address.
- R9: When `load` and a step (`step_n` low) fall on the same edge, the load wins and `beat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `ext_addr` and restart the burst |
| ext_addr | input | ADDR_W | External start address |
| step_n | input | 1 | Active-low advance; high holds the current beat |
| interleave | input | 1 | Ordering select: 1 interleaved, 0 linear; held static |
| burst_addr | output | ADDR_W | Current burst address |
| beat | output | 2 | Current beat index 0..3 |

## Verification
The bench builds the block with `ADDR_W` set to 10. At that width, start addresses with distinct upper patterns exercise every upper bit while the low pair runs through all four starting values.

The ordering input changes only across a reset. Both the linear and the interleaved sequences are therefore covered from several starting values. The stimulus also reaches wrap-around, held beats, a reload mid-burst, and a load that coincides with a step.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              step_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [1:0]        beat
);

  localparam int UP_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        low_lin;
  logic [1:0]        low_ilv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (!step_n) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign low_lin    = base_q[1:0] + cnt_q;
  assign low_ilv    = base_q[1:0] ^ cnt_q;
  assign burst_addr = {base_q[ADDR_W-1 -: UP_W], interleave ? low_ilv : low_lin};
  assign beat       = cnt_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              step_n,
  input logic              interleave,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [1:0]        beat
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == 2'd0) && (burst_addr == $past(ext_addr)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> $stable(burst_addr) && $stable(beat));

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

  // R8
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n) |=> beat == $past(beat) + 2'd1);

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!interleave && !load && !step_n) |=> burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1);

  // R4
  ilv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (interleave && beat == 2'd0 && !load && !step_n) |=>
      burst_addr[1:0] == ($past(burst_addr[1:0]) ^ 2'd1));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .ext_addr(ext_addr),
  .step_n(step_n), .interleave(interleave),
  .burst_addr(burst_addr), .beat(beat)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int W = 10;

  typedef struct {
    logic [W-1:0] addr;
    logic [1:0]   bt;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] ext_addr = '0;
  logic         step_n = 1'b1;
  logic         interleave = 1'b0;
  logic [W-1:0] burst_addr;
  logic [1:0]   beat;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t q[$];

  logic [W-1:0] m_base = '0;
  logic [1:0]   m_cnt = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ext_addr(ext_addr),
    .step_n(step_n), .interleave(interleave),
    .burst_addr(burst_addr), .beat(beat)
  );

  function automatic logic [W-1:0] model_addr();
    logic [1:0] lo;
    lo = interleave ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[W-1:2], lo};
  endfunction

  task automatic cyc(input logic ld, input logic [W-1:0] a, input logic st_n, input string tag);
    exp_t e;
    @(negedge clk);
    load = ld; ext_addr = a; step_n = st_n;
    @(posedge clk);
    if (ld) begin m_base = a; m_cnt = 2'd0; end
    else if (!st_n) m_cnt = m_cnt + 2'd1;
    e.addr = model_addr(); e.bt = m_cnt; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (burst_addr !== e.addr || beat !== e.bt) begin
        n_bad++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 e.tag, burst_addr, beat, e.addr, e.bt);
      end
    end
  end

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0; step_n = 1'b1; interleave = ilv;
    m_base = '0; m_cnt = '0;
    #3;
    n_vec++;
    if (burst_addr !== '0 || beat !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", burst_addr, beat);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R2 R3 R6: linear from 01
    cyc(1'b1, 10'h2A5, 1'b1, "R2");
    cyc(1'b0, 10'h3FF, 1'b0, "R3");
    cyc(1'b0, 10'h000, 1'b0, "R3");
    cyc(1'b0, 10'h155, 1'b0, "R6");
    // R8 wrap
    cyc(1'b0, 10'h000, 1'b0, "R8");
    // R5 hold
    cyc(1'b0, 10'h0F0, 1'b1, "R5");
    cyc(1'b0, 10'h00F, 1'b1, "R5");
    cyc(1'b0, 10'h000, 1'b0, "R3");
    // R7 reload mid-burst
    cyc(1'b1, 10'h1CE, 1'b1, "R7");
    cyc(1'b0, 10'h000, 1'b0, "R3");
    cyc(1'b0, 10'h000, 1'b0, "R3");
    cyc(1'b0, 10'h000, 1'b0, "R8");
    cyc(1'b0, 10'h000, 1'b0, "R8");
    // R9 load with step
    cyc(1'b0, 10'h000, 1'b0, "R3");
    cyc(1'b1, 10'h313, 1'b0, "R9");
    cyc(1'b0, 10'h000, 1'b1, "R5");
    cyc(1'b0, 10'h000, 1'b0, "R3");
    repeat (3) @(negedge clk);

    do_reset(1'b1);
    // R4 interleaved from 10
    cyc(1'b1, 10'h2AA, 1'b1, "R2");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b1, "R5");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b0, "R8");
    // R4 interleaved from 11
    cyc(1'b1, 10'h157, 1'b1, "R2");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h3FF, 1'b0, "R6");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b0, "R8");
    // R7 in interleaved mode, starts 00 and 01
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b1, 10'h0C0, 1'b0, "R9");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b1, 10'h201, 1'b1, "R7");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    cyc(1'b0, 10'h000, 1'b0, "R4");
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule